// File: doc/BRIEF.md
# Four-Sensor Serial Thermometer Controller

This block sits behind a processor bus and drives four three-wire digital thermometers in lockstep. Software toggles a held clock-low flag and writes one bit at a time to build an 8-bit command least-significant bit first. After that it reads the selected result one bit position per access. Every read returns that bit position from all four sensors at once, packed so that bit i comes from sensor i.

The controller keeps, for each sensor, a configuration register and a 9-bit temperature register in half-degree units. It also holds the command, the command bit count, a write data word and a shared read/data position. Temperatures power up at 44 (22 degrees) and can be reloaded as a group from a port. Configuration registers hold the CPU-mode status value 0x02.

Top module: `thermo_quad_ctrl`

## Requirements
- R1: After reset, rdata_o is 0, data_word_o is 0, the clock-low flag is clear, every temperature register holds 44 and every configuration register holds 0x02.
- R2: A write to address 0 with code 0 clears the command, command bit count, data word and position, and leaves the clock-low flag as it is. Code 1 sets the clock-low flag and code 2 clears it. Any other code has no effect.
- R3: A write to address 1 with any value other than 2 changes no state while the clock-low flag is clear.
- R4: A write of value 2 to address 1 sets the position to 0, whatever the clock-low flag holds.
- R5: While fewer than 8 command bits are in, each accepted address-1 write adds one command bit at the next position, LSB first. The bit is 1 for value 1 and 0 for any other value.
- R6: A completed command equal to 0xEE clears the command, bit count, data word and position.
- R7: With command 0xAC complete, each read of address 2 returns, in bit i, bit <position> of sensor i's configuration register and advances the position. The read at position 7 also clears the command, bit count, data word and position.
- R8: With command 0xAA complete, reads work the same way on the temperature registers, and the clearing read is the one at position 8.
- R9: A read of address 2 with no complete command, or with a complete command other than 0xAC or 0xAA, returns 0 and leaves the position unchanged.
- R10: After the command is complete, each accepted address-1 write other than 2 sets data_word_o bit <position> when the value is 1 and advances the position. The position saturates at 31, and bits beyond 15 are dropped.
- R11: A cycle with temp_ld_i high loads sensor i's temperature register from temp_val_i[9i+8:9i].
- R12: rdata_o changes only in the cycle after an address-2 read. Writes to address 2 and reads of addresses 0, 1 and 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Bus access strobe, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | 0 control, 1 data write, 2 data read |
| wdata_i | input | 8 | Write value (code) |
| rdata_o | output | 4 | Registered read data, bit i from sensor i |
| temp_ld_i | input | 1 | Load all temperature registers |
| temp_val_i | input | 36 | Four packed 9-bit temperatures, sensor 0 lowest |
| data_word_o | output | 16 | Data word shifted in after the command |

## Verification
Default temperatures are read first. Then distinct temperatures are loaded per sensor, so that a swapped bit lane or a wrong bit order shows up in the packed read value. Directed sequences cover reads of exactly 8 and 9 bits, followed by a further read that must return zero. They also cover start-convert clearing, unknown commands, and writes made with the clock flag high. Seeded random streams mix control codes, bit writes, enable-read, stray addresses and whole commands. This drives the position into data-word shifting and saturation, and a bench model tracks the expected read data and data word.

// File: rtl/thermo_pkg.sv
package thermo_pkg;
  localparam int unsigned CMD_W  = 8;
  localparam int unsigned CFG_W  = 8;
  localparam int unsigned TEMP_W = 9;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DWR  = 2'd1;
  localparam logic [1:0] ADDR_DRD  = 2'd2;

  localparam logic [7:0] CTRL_RESET = 8'd0;
  localparam logic [7:0] CTRL_LOW   = 8'd1;
  localparam logic [7:0] CTRL_HIGH  = 8'd2;

  localparam logic [7:0] DWR_HIGH   = 8'd1;
  localparam logic [7:0] DWR_ENRD   = 8'd2;

  localparam logic [CMD_W-1:0] CMD_START = 8'hEE;
  localparam logic [CMD_W-1:0] CMD_RDCFG = 8'hAC;
  localparam logic [CMD_W-1:0] CMD_RDTMP = 8'hAA;
endpackage

// File: rtl/thermo_cmd_shift.sv
module thermo_cmd_shift
  import thermo_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned POS_W  = 5
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      ctrl_wr_i,
  input  logic                      dat_wr_i,
  input  logic [7:0]                code_i,
  input  logic                      rd_step_i,
  input  logic                      rd_clear_i,
  output logic [CMD_W-1:0]          cmd_o,
  output logic [$clog2(CMD_W+1)-1:0] cmd_pos_o,
  output logic [POS_W-1:0]          pos_o,
  output logic [DATA_W-1:0]         data_word_o
);
  localparam int unsigned CPOS_W = $clog2(CMD_W+1);
  localparam logic [CPOS_W-1:0] CPOS_FULL = CPOS_W'(CMD_W);
  localparam logic [CPOS_W-1:0] CPOS_LAST = CPOS_W'(CMD_W-1);

  logic                clk_low_q;
  logic [CMD_W-1:0]    cmd_q, cmd_nxt;
  logic [CPOS_W-1:0]   cpos_q;
  logic [POS_W-1:0]    pos_q;
  logic [DATA_W-1:0]   dword_q;
  logic                cmd_done;

  assign cmd_done = (cpos_q == CPOS_FULL);
  assign cmd_nxt  = (code_i == DWR_HIGH) ? (cmd_q | (CMD_W'(1) << cpos_q)) : cmd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_low_q <= 1'b0;
      cmd_q     <= '0;
      cpos_q    <= '0;
      pos_q     <= '0;
      dword_q   <= '0;
    end else if (ctrl_wr_i) begin
      case (code_i)
        CTRL_RESET: begin
          cmd_q <= '0; cpos_q <= '0; pos_q <= '0; dword_q <= '0;
        end
        CTRL_LOW:  clk_low_q <= 1'b1;
        CTRL_HIGH: clk_low_q <= 1'b0;
        default: ;
      endcase
    end else if (rd_clear_i) begin
      cmd_q <= '0; cpos_q <= '0; pos_q <= '0; dword_q <= '0;
    end else if (rd_step_i) begin
      if (pos_q != '1) pos_q <= pos_q + 1'b1;
    end else if (dat_wr_i) begin
      if (code_i == DWR_ENRD) begin
        pos_q <= '0;
      end else if (clk_low_q) begin
        if (!cmd_done) begin
          if (cpos_q == CPOS_LAST && cmd_nxt == CMD_START) begin
            cmd_q <= '0; cpos_q <= '0; pos_q <= '0; dword_q <= '0;
          end else begin
            cmd_q  <= cmd_nxt;
            cpos_q <= cpos_q + 1'b1;
          end
        end else begin
          if (code_i == DWR_HIGH) dword_q <= dword_q | (DATA_W'(1) << pos_q);
          if (pos_q != '1) pos_q <= pos_q + 1'b1;
        end
      end
    end
  end

  assign cmd_o       = cmd_q;
  assign cmd_pos_o   = cpos_q;
  assign pos_o       = pos_q;
  assign data_word_o = dword_q;

  AST_CPOS_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpos_q <= CPOS_FULL); // R5
  AST_IGNORE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && !clk_low_q && code_i != DWR_ENRD) |=>
      ($stable(cmd_q) && $stable(cpos_q) && $stable(pos_q) && $stable(dword_q))); // R3
  AST_ENRD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr_i && code_i == DWR_ENRD) |=> (pos_q == '0)); // R4
  AST_CTRL_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && code_i == CTRL_RESET) |=>
      (cmd_q == '0 && cpos_q == '0 && pos_q == '0 && dword_q == '0)); // R2
  AST_CLK_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr_i && code_i == CTRL_LOW) |=> clk_low_q); // R2
endmodule

// File: rtl/thermo_sensor_bank.sv
module thermo_sensor_bank
  import thermo_pkg::*;
#(
  parameter int unsigned NUM_SENS = 4,
  parameter int unsigned POS_W    = 5,
  parameter logic [CFG_W-1:0]  CFG_INIT  = 8'h02,
  parameter logic [TEMP_W-1:0] TEMP_INIT = 9'd44
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       temp_ld_i,
  input  logic [NUM_SENS*TEMP_W-1:0] temp_val_i,
  input  logic                       sel_temp_i,
  input  logic [POS_W-1:0]           pos_i,
  output logic [NUM_SENS-1:0]        bits_o
);
  for (genvar g = 0; g < NUM_SENS; g++) begin : g_sens
    logic [TEMP_W-1:0] temp_q;
    logic [CFG_W-1:0]  cfg_q;
    logic [TEMP_W-1:0] temp_sh;
    logic [CFG_W-1:0]  cfg_sh;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        temp_q <= TEMP_INIT;
        cfg_q  <= CFG_INIT;
      end else if (temp_ld_i) begin
        temp_q <= temp_val_i[g*TEMP_W +: TEMP_W];
      end
    end

    assign temp_sh   = temp_q >> pos_i;
    assign cfg_sh    = cfg_q >> pos_i;
    assign bits_o[g] = sel_temp_i ? temp_sh[0] : cfg_sh[0];

    AST_TEMP_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      temp_ld_i |=> (temp_q == $past(temp_val_i[g*TEMP_W +: TEMP_W]))); // R11
  end
endmodule

// File: rtl/thermo_quad_ctrl.sv
module thermo_quad_ctrl
  import thermo_pkg::*;
#(
  parameter int unsigned NUM_SENS = 4,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned CFG_LEN  = 8,
  parameter int unsigned TEMP_LEN = 9
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [1:0]                 addr_i,
  input  logic [7:0]                 wdata_i,
  output logic [NUM_SENS-1:0]        rdata_o,
  input  logic                       temp_ld_i,
  input  logic [NUM_SENS*TEMP_W-1:0] temp_val_i,
  output logic [DATA_W-1:0]          data_word_o
);
  localparam int unsigned POS_W  = $clog2(DATA_W) + 1;
  localparam int unsigned CPOS_W = $clog2(CMD_W+1);

  logic ctrl_wr, dat_wr, rd_acc;
  logic [CMD_W-1:0]    cmd;
  logic [CPOS_W-1:0]   cmd_pos;
  logic [POS_W-1:0]    pos;
  logic                cmd_done, is_cfg, is_tmp, rd_known, rd_last;
  logic [NUM_SENS-1:0] bits;

  assign ctrl_wr = req_i && we_i && addr_i == ADDR_CTRL;
  assign dat_wr  = req_i && we_i && addr_i == ADDR_DWR;
  assign rd_acc  = req_i && !we_i && addr_i == ADDR_DRD;

  assign cmd_done = (cmd_pos == CPOS_W'(CMD_W));
  assign is_cfg   = cmd_done && cmd == CMD_RDCFG;
  assign is_tmp   = cmd_done && cmd == CMD_RDTMP;
  assign rd_known = is_cfg || is_tmp;
  assign rd_last  = is_cfg ? (pos == POS_W'(CFG_LEN-1)) : (pos == POS_W'(TEMP_LEN-1));

  thermo_cmd_shift #(.DATA_W(DATA_W), .POS_W(POS_W)) u_shift (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ctrl_wr_i   (ctrl_wr),
    .dat_wr_i    (dat_wr),
    .code_i      (wdata_i),
    .rd_step_i   (rd_acc && rd_known && !rd_last),
    .rd_clear_i  (rd_acc && rd_known && rd_last),
    .cmd_o       (cmd),
    .cmd_pos_o   (cmd_pos),
    .pos_o       (pos),
    .data_word_o (data_word_o)
  );

  thermo_sensor_bank #(.NUM_SENS(NUM_SENS), .POS_W(POS_W)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .temp_ld_i  (temp_ld_i),
    .temp_val_i (temp_val_i),
    .sel_temp_i (is_tmp),
    .pos_i      (pos),
    .bits_o     (bits)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     rdata_o <= '0;
    else if (rd_acc) rdata_o <= rd_known ? bits : '0;
  end

  AST_UNKNOWN_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && !rd_known) |=> (rdata_o == '0 && $stable(pos))); // R9
  AST_READ_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_acc && rd_known && rd_last) |=> (cmd_pos == '0 && pos == '0)); // R7 R8
  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_acc |=> $stable(rdata_o)); // R12
endmodule

// File: tb/thermo_quad_ctrl_test.sv
module thermo_quad_ctrl_test;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, temp_ld_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [35:0] temp_val_i = '0;
  logic [3:0]  rdata_o;
  logic [15:0] data_word_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  int m_low, m_cmd, m_cpos, m_pos, m_dword, m_rd;
  int m_tv[4];

  thermo_quad_ctrl uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .temp_ld_i(temp_ld_i),
    .temp_val_i(temp_val_i), .data_word_o(data_word_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic void m_clear();
    m_cmd = 0; m_cpos = 0; m_pos = 0; m_dword = 0;
  endfunction

  function automatic void m_access(input bit we, input int a, input int d);
    int nc, len, b;
    if (we && a == 0) begin
      if (d == 0) m_clear();
      else if (d == 1) m_low = 1;
      else if (d == 2) m_low = 0;
    end else if (we && a == 1) begin
      if (d == 2) m_pos = 0;
      else if (m_low != 0) begin
        if (m_cpos < 8) begin
          nc = (d == 1) ? (m_cmd | (1 << m_cpos)) : m_cmd;
          if (m_cpos == 7 && nc == 'hEE) m_clear();
          else begin m_cmd = nc; m_cpos++; end
        end else begin
          if (d == 1) m_dword = (m_dword | (1 << m_pos)) & 'hFFFF;
          if (m_pos != 31) m_pos++;
        end
      end
    end else if (!we && a == 2) begin
      if (m_cpos == 8 && (m_cmd == 'hAC || m_cmd == 'hAA)) begin
        len = (m_cmd == 'hAC) ? 8 : 9;
        m_rd = 0;
        for (int i = 0; i < 4; i++) begin
          b = (m_cmd == 'hAC) ? ((2 >> m_pos) & 1) : ((m_tv[i] >> m_pos) & 1);
          m_rd |= b << i;
        end
        if (m_pos == len - 1) m_clear();
        else if (m_pos != 31) m_pos++;
      end else m_rd = 0;
    end
  endfunction

  task automatic acc(input bit we, input int a, input int d, input string req);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a[1:0]; wdata_i = d[7:0];
    @(negedge clk_i);
    req_i = 1'b0;
    m_access(we, a, d);
    check(req, int'(rdata_o), m_rd);
    check(req, int'(data_word_o), m_dword);
  endtask

  task automatic send_cmd(input int c, input string req);
    for (int i = 0; i < 8; i++) acc(1'b1, 1, (c >> i) & 1, req);
  endtask

  task automatic load_temps(input int t0, input int t1, input int t2, input int t3);
    @(negedge clk_i);
    temp_val_i = {t3[8:0], t2[8:0], t1[8:0], t0[8:0]};
    temp_ld_i = 1'b1;
    @(negedge clk_i);
    temp_ld_i = 1'b0;
    m_tv[0] = t0; m_tv[1] = t1; m_tv[2] = t2; m_tv[3] = t3;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int op, v;
    void'($urandom(32'h5eed_71c3));
    m_low = 0; m_rd = 0; m_clear();
    for (int i = 0; i < 4; i++) m_tv[i] = 44;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", int'(rdata_o), 0);
    check("R1", int'(data_word_o), 0);

    // R3: clock flag clear after reset, command bits ignored
    send_cmd('hAA, "R3");
    acc(1'b0, 2, 0, "R9");
    // R1 defaults: read temperature 44 on every sensor
    acc(1'b1, 0, 1, "R2");
    send_cmd('hAA, "R5");
    for (int i = 0; i < 9; i++) acc(1'b0, 2, 0, "R8");
    acc(1'b0, 2, 0, "R9");
    // R1 config value
    send_cmd('hAC, "R5");
    for (int i = 0; i < 8; i++) acc(1'b0, 2, 0, "R7");
    acc(1'b0, 2, 0, "R9");
    // R11 distinct temperatures
    load_temps('h1A5, 'h05A, 'h133, 'h0CC);
    send_cmd('hAA, "R11");
    for (int i = 0; i < 4; i++) acc(1'b0, 2, 0, "R11");
    acc(1'b1, 1, 2, "R4");
    acc(1'b1, 0, 2, "R2");
    acc(1'b1, 1, 1, "R3");
    acc(1'b1, 1, 2, "R4");
    for (int i = 0; i < 9; i++) acc(1'b0, 2, 0, "R8");
    // R6 start convert clears
    acc(1'b1, 0, 1, "R2");
    send_cmd('hEE, "R6");
    acc(1'b0, 2, 0, "R6");
    // R10 data shift after command
    send_cmd('hAA, "R10");
    acc(1'b1, 1, 1, "R10");
    acc(1'b1, 1, 0, "R10");
    acc(1'b1, 1, 1, "R10");
    acc(1'b0, 2, 0, "R10");
    acc(1'b1, 0, 0, "R2");
    // R9 unknown command
    send_cmd('h5C, "R9");
    acc(1'b0, 2, 0, "R9");
    acc(1'b0, 2, 0, "R9");
    // R12 stray addresses
    acc(1'b1, 2, 1, "R12");
    acc(1'b0, 0, 0, "R12");
    acc(1'b0, 3, 0, "R12");
    acc(1'b1, 3, 0, "R12");
    acc(1'b1, 0, 7, "R2");

    for (int n = 0; n < 1500; n++) begin
      op = $urandom_range(0, 19);
      if (op == 0) load_temps($urandom_range(0, 511), $urandom_range(0, 511),
                              $urandom_range(0, 511), $urandom_range(0, 511));
      else if (op <= 2) acc(1'b1, 0, $urandom_range(0, 3), "R2");
      else if (op <= 8) begin
        v = $urandom_range(0, 9);
        acc(1'b1, 1, (v < 5) ? 1 : (v < 8) ? 0 : (v == 8) ? 2 : 3, "R10");
      end else if (op <= 14) acc(1'b0, 2, 0, "R7");
      else if (op == 15) acc($urandom_range(0, 1) == 1, 3, $urandom_range(0, 255), "R12");
      else begin
        v = $urandom_range(0, 3);
        acc(1'b1, 0, 1, "R2");
        if ($urandom_range(0, 1) == 1) acc(1'b1, 0, 0, "R2");
        send_cmd((v == 0) ? 'hAC : (v == 1) ? 'hAA : (v == 2) ? 'hEE : $urandom_range(0, 255), "R5");
      end
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule